// File: doc/BRIEF.md
# PC-Relative Branch Resolver

This block works out where a branch goes for a 16-bit, byte-addressed RISC core. Each cycle it takes an instruction word, the address of the instruction that follows it, and four status flags: overflow (V), negative (N), zero (Z) and carry (C). It recognises two branch forms:

- A long-reach branch-with-link.
- A shorter conditional branch with eight condition selectors.

For either form it sign-extends the offset field and scales it from instruction words to bytes. It adds the result to the next-instruction address. It reports whether the branch is taken, the new PC, and, for the link form, the return address that the register file should store.

The instruction stream is halfword aligned, so offsets count 2-byte words. Each stored offset bit therefore reaches twice as far as a byte count would. Offsets are relative to the instruction after the branch, so a word offset of -1 branches to the branch itself. All address arithmetic wraps modulo 2^16.

The result is computed combinationally. It is captured in an output register when `REG_OUT` is 1, which is the default, giving a latency of one cycle. With `REG_OUT` at 0 the outputs follow the inputs directly.

Top module: `branch_resolver`

## Requirements
- R1: An instruction whose bits 15:13 are 000 is a branch-with-link. It is always taken. Its word offset is bits 12:0 read as a two's-complement number, with bit 12 as the sign.
- R2: For a branch-with-link, `link_we_o` is 1 and `link_o` equals `pc_next_i`. For every other instruction, `link_we_o` is 0 and `link_o` is 0.
- R3: An instruction whose bits 15:13 are 001 is a conditional branch. Its word offset is bits 9:0 read as two's complement, with bit 9 as the sign. Bits 12:10 select the condition.
- R4: For a taken branch, `target_o` equals `pc_next_i` plus twice the signed word offset. The target therefore keeps the parity of `pc_next_i`.
- R5: The condition selector codes are:
  - 000: taken when Z=1.
  - 001: taken when Z=0.
  - 010: taken when C=1.
  - 011: taken when C=0.
  - 100: taken when N=1.
  - 101: taken when N equals V.
  - 110: taken when N differs from V.
  - 111: always taken.
- R6: An instruction that is not taken gives `taken_o`=0 and `target_o`=`pc_next_i`. This covers a conditional branch whose condition is false and any instruction with bits 15:13 outside 000 and 001.
- R7: Target arithmetic is modulo 2^16. A target past 0xFFFF or below 0x0000 wraps with no other effect.
- R8: A word offset of -1 yields `target_o` = `pc_next_i` - 2, which is the branch's own address.
- R9: With `REG_OUT`=1, all outputs are 0 while `rst_n` is low. Outside reset, the outputs reflect the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Instruction word under evaluation |
| pc_next_i | input | 16 | Address of the instruction following the branch |
| flag_v_i | input | 1 | Overflow status flag |
| flag_n_i | input | 1 | Negative status flag |
| flag_z_i | input | 1 | Zero status flag |
| flag_c_i | input | 1 | Carry status flag |
| taken_o | output | 1 | Branch taken |
| target_o | output | 16 | Next PC: branch target or `pc_next_i` |
| link_we_o | output | 1 | Link register write enable |
| link_o | output | 16 | Return address to be stored |

## Verification
Every one of the 8192 link-form offsets is applied, which separates a correct sign bit and scaling from an off-by-one field width. The full 1024-value conditional offset range is swept under the always-taken selector. All eight selectors are then crossed with all sixteen flag combinations, which distinguishes each condition, including the signed N-versus-V pair, from its neighbours. Instructions from the six non-branch prefixes confirm that nothing is taken or linked. PCs near 0x0000 and 0xFFFF are combined with the extreme offsets to expose wrapping errors.

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] instr_i,
  input  logic [15:0] pc_next_i,
  input  logic        flag_v_i,
  input  logic        flag_n_i,
  input  logic        flag_z_i,
  input  logic        flag_c_i,
  output logic        taken_o,
  output logic [15:0] target_o,
  output logic        link_we_o,
  output logic [15:0] link_o
);
  localparam int W       = 16;
  localparam int LONG_W  = 13;
  localparam int SHORT_W = 10;

  logic          is_link, is_cond, cond_ok;
  logic [W-1:0]  ofs_long, ofs_short, ofs_bytes;
  logic          n_taken;
  logic [W-1:0]  n_target, n_link;

  assign is_link = instr_i[15:13] == 3'b000;
  assign is_cond = instr_i[15:13] == 3'b001;

  assign ofs_long  = {{(W-LONG_W-1){instr_i[LONG_W-1]}}, instr_i[LONG_W-1:0], 1'b0};
  assign ofs_short = {{(W-SHORT_W-1){instr_i[SHORT_W-1]}}, instr_i[SHORT_W-1:0], 1'b0};
  assign ofs_bytes = is_link ? ofs_long : ofs_short;

  always_comb begin
    unique case (instr_i[12:10])
      3'd0:    cond_ok = flag_z_i;
      3'd1:    cond_ok = !flag_z_i;
      3'd2:    cond_ok = flag_c_i;
      3'd3:    cond_ok = !flag_c_i;
      3'd4:    cond_ok = flag_n_i;
      3'd5:    cond_ok = flag_n_i == flag_v_i;
      3'd6:    cond_ok = flag_n_i != flag_v_i;
      default: cond_ok = 1'b1;
    endcase
  end

  assign n_taken  = is_link | (is_cond & cond_ok);
  assign n_target = n_taken ? pc_next_i + ofs_bytes : pc_next_i;
  assign n_link   = is_link ? pc_next_i : '0;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          taken_o   <= 1'b0;
          target_o  <= '0;
          link_we_o <= 1'b0;
          link_o    <= '0;
        end else begin
          taken_o   <= n_taken;
          target_o  <= n_target;
          link_we_o <= is_link;
          link_o    <= n_link;
        end
      end

      logic live_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
      end

      a_r1_link_taken: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> taken_o);
      a_r1_link_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && link_we_o) |-> $past(instr_i[15:13]) == 3'b000);
      a_r2_link_value: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && link_we_o) |-> link_o == $past(pc_next_i));
      a_r4_parity: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> target_o[0] == $past(pc_next_i[0]));
      a_r5_signed_ge: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(instr_i[15:10]) == 6'b001101)
          |-> taken_o == ($past(flag_n_i) == $past(flag_v_i)));
      a_r6_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !taken_o) |-> (target_o == $past(pc_next_i) && !link_we_o));
      a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (!taken_o && !link_we_o && target_o == '0));
    end else begin : g_comb
      assign taken_o   = n_taken;
      assign target_o  = n_target;
      assign link_we_o = is_link;
      assign link_o    = n_link;
    end
  endgenerate
endmodule

// File: tb/branch_resolver_tb.sv
module branch_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0, pc = '0;
  logic        fv = 0, fn = 0, fz = 0, fc = 0;
  logic        taken, link_we;
  logic [15:0] target, link;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  branch_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .pc_next_i(pc),
    .flag_v_i(fv), .flag_n_i(fn), .flag_z_i(fz), .flag_c_i(fc),
    .taken_o(taken), .target_o(target), .link_we_o(link_we), .link_o(link)
  );

  function automatic bit cond_ref(int sel, bit v, bit n, bit z, bit c);
    case (sel)
      0: return z;
      1: return !z;
      2: return c;
      3: return !c;
      4: return n;
      5: return n == v;
      6: return n != v;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(string req, bit et, int etgt, bit elw, int elink);
    checks++;
    if (taken !== et || target !== etgt[15:0] || link_we !== elw || link !== elink[15:0]) begin
      errors++;
      $display("FAIL %s instr=%h pc=%h: got taken=%0b target=%h lwe=%0b link=%h, expected taken=%0b target=%h lwe=%0b link=%h",
               req, instr, pc, taken, target, link_we, link, et, etgt[15:0], elw, elink[15:0]);
    end
  endtask

  // drive on negedge, output registered at the next posedge, sample on the following negedge
  task automatic apply(logic [15:0] ins, logic [15:0] p, logic [3:0] vnzc);
    instr = ins; pc = p; {fv, fn, fz, fc} = vnzc;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic try_link(int off, int p, string req);
    int e;
    apply({3'b000, off[12:0]}, p[15:0], 4'h0);
    e = (p + 2 * off) & 16'hFFFF;
    check(req, 1'b1, e, 1'b1, p);
  endtask

  task automatic try_cond(int sel, int off, int p, logic [3:0] vnzc, string req);
    bit t;
    int e;
    apply({3'b001, sel[2:0], off[9:0]}, p[15:0], vnzc);
    t = cond_ref(sel, vnzc[3], vnzc[2], vnzc[1], vnzc[0]);
    e = t ? ((p + 2 * off) & 16'hFFFF) : p;
    check(req, t, e, 1'b0, 0);
  endtask

  initial begin
    @(negedge clk);
    instr = 16'h0123; pc = 16'h4000;
    @(posedge clk); @(negedge clk);
    check("R9 reset", 1'b0, 0, 1'b0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4: every long offset
    for (int o = -4096; o < 4096; o++) try_link(o, 16'h8000, "R1 link offset");
    try_link(4095, 16'h2000, "R1 max forward");
    try_link(-4096, 16'h6000, "R1 max backward");
    try_link(-1, 16'h1234, "R8 link self");
    try_link(1, 16'h0010, "R2 link value");

    // R3 R4: every short offset under always-taken
    for (int o = -512; o < 512; o++) try_cond(7, o, 16'h3000, 4'h0, "R3 cond offset");
    try_cond(7, 511, 16'h0400, 4'h0, "R3 max forward");
    try_cond(7, -512, 16'h0400, 4'h0, "R3 max backward");
    try_cond(7, -1, 16'h5556, 4'h0, "R8 cond self");

    // R5: all selectors x all flag sets
    for (int s = 0; s < 8; s++)
      for (int f = 0; f < 16; f++) begin
        try_cond(s, 37, 16'h1000, f[3:0], "R5 condition");
        try_cond(s, -200, 16'h1000, f[3:0], "R5 condition back");
      end

    // R6: non-branch prefixes
    for (int g = 2; g < 8; g++)
      for (int f = 0; f < 16; f++) begin
        apply({g[2:0], 13'h1FFF ^ f[12:0]}, 16'hABCE, f[3:0]);
        check("R6 non-branch", 1'b0, 16'hABCE, 1'b0, 0);
      end
    try_cond(0, 100, 16'h2222, 4'b0000, "R6 cond false");

    // R7: wrap
    try_link(4095, 16'hFFFE, "R7 link wrap forward");
    try_link(-4096, 16'h0002, "R7 link wrap backward");
    try_cond(7, 511, 16'hFF00, 4'h0, "R7 cond wrap forward");
    try_cond(7, -512, 16'h0100, 4'h0, "R7 cond wrap backward");
    try_link(0, 16'h0001, "R4 odd pc parity");

    // R9: reset again mid-stream
    instr = 16'h0005; pc = 16'h7000;
    @(posedge clk); #1 rst_n = 1'b0; @(negedge clk);
    check("R9 async reset", 1'b0, 0, 1'b0, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); checks++; errors++;
            $display("FAIL watchdog expired"); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule